// File: doc/BRIEF.md
# Quarter-Square Table-Lookup Multiplier

This block forms the unsigned product of two N-bit operands without an array of partial products. For each operand pair it derives two indices: the floored half of the operand sum, and the magnitude of the floored half of their signed difference. It then reads the square of each index from a square unit. The difference of the two squares is the product when the operands share their lowest bit. When the lowest bits differ, the second operand is added as a correction term.

The datapath is pipelined over two registered stages. The first stage holds the two squares and the correction term. The second stage holds the combined product. A new operand pair may be offered every cycle, and each result appears two cycles after its operands. The square unit is either a constant table built at elaboration or a shift-and-add squaring network. A parameter selects between them.

Top module: `qsq_mult`

## Requirements
- R1: The first index is the full (N+1)-bit operand sum shifted right by one, so no carry is lost; all-ones times all-ones yields (2^N-1)^2.
- R2: When bit 0 of A equals bit 0 of B, the product equals x^2 - y^2, with x = floor((A+B)/2) and y = floor((A-B)/2).
- R3: When bit 0 of A differs from bit 0 of B, the product equals x^2 - y^2 + B.
- R4: A negative odd difference is floored toward minus infinity, not truncated toward zero; A=1, B=2 gives y = -1 and product 2.
- R5: An operand pair accepted with `in_valid` high in cycle t produces `out_valid` high in cycle t+2, with `product` equal to A*B for that pair.
- R6: While `rst_i` is high, `out_valid` and `product` are cleared to 0 at each rising clock edge.
- R7: `out_valid` is high only two cycles after an accepted pair. While it is low, `product` keeps its last value.
- R8: Operand pairs offered on consecutive cycles each produce their own correct result on consecutive cycles.
- R9: The table variant (`SQ_IMPL` = SQ_IMPL_TABLE) and the logic variant (SQ_IMPL_LOGIC) produce identical products for the same operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair on `a`/`b` is valid this cycle |
| a | input | N | First unsigned operand |
| b | input | N | Second unsigned operand (the correction term) |
| out_valid | output | 1 | `product` carries a new result |
| product | output | 2N | Unsigned product A*B |

## Verification
The bench builds two instances. The first uses the default N=16, which selects the shift-and-add squaring network; there the all-ones operands push the sum into its carry bit, and the difference magnitude reaches 2^15. The second uses N=6 with the constant 64-entry table, so the lookup path is exercised as well. Both are driven from the same stream, so the two variants are compared on every operand pair. Random pairs are mixed with directed equal, zero, one, all-ones and mixed-parity pairs. Both dense back-to-back and gapped streams are applied to check the two-cycle spacing and the hold of `product` between results.

// File: rtl/qsq_pkg.sv
package qsq_pkg;

   typedef enum logic [0:0] {
      SQ_IMPL_TABLE = 1'b0,
      SQ_IMPL_LOGIC = 1'b1
   } sq_impl_e;

   localparam int unsigned QSQ_MAX_N       = 32;
   localparam int unsigned QSQ_MAX_TABLE_N = 12;

   // Shift-and-add squaring of an operand of up to QSQ_MAX_N bits.
   function automatic logic [2*QSQ_MAX_N-1:0] sq_shift_add(
      input logic [QSQ_MAX_N-1:0] v
   );
      logic [2*QSQ_MAX_N-1:0] acc;
      logic [2*QSQ_MAX_N-1:0] addend;
      acc    = '0;
      addend = {{QSQ_MAX_N{1'b0}}, v};
      for (int k = 0; k < QSQ_MAX_N; k++) begin
         if (v[k]) acc = acc + addend;
         addend = addend << 1;
      end
      return acc;
   endfunction

endpackage

// File: rtl/qsq_operand_prep.sv
module qsq_operand_prep #(
   parameter int unsigned N = 16
) (
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic [N-1:0]   x_idx,
   output logic [N-1:0]   y_idx,
   output logic [2*N-1:0] corr
);
   localparam int unsigned W2 = 2 * N;

   logic [N:0]        sum_full;
   logic signed [N:0] diff_s;
   logic signed [N:0] y_floor;
   logic [N:0]        y_mag;
   logic              par_odd;
   logic              unused_bits;

   // Full-width sum keeps the carry so x never wraps.
   assign sum_full = {1'b0, a} + {1'b0, b};
   assign x_idx    = sum_full[N:1];

   // Arithmetic shift of the signed difference floors toward minus infinity.
   assign diff_s  = $signed({1'b0, a}) - $signed({1'b0, b});
   assign y_floor = diff_s >>> 1;
   assign y_mag   = y_floor[N] ? N'(0) - y_floor : y_floor;
   assign y_idx   = y_mag[N-1:0];

   assign par_odd = a[0] ^ b[0];
   assign corr    = par_odd ? {{N{1'b0}}, b} : {W2{1'b0}};

   assign unused_bits = ^{sum_full[0], y_mag[N]};
endmodule

// File: rtl/qsq_square_unit.sv
module qsq_square_unit #(
   parameter int unsigned        N       = 16,
   parameter qsq_pkg::sq_impl_e  SQ_IMPL = qsq_pkg::SQ_IMPL_LOGIC
) (
   input  logic [N-1:0]   idx,
   output logic [2*N-1:0] sq
);
   localparam int unsigned W2    = 2 * N;
   localparam int unsigned DEPTH = 1 << N;

   generate
      if (SQ_IMPL == qsq_pkg::SQ_IMPL_TABLE) begin : g_table
         if (N > qsq_pkg::QSQ_MAX_TABLE_N) begin : g_too_big
            $error("qsq_square_unit: table variant limited to small N");
         end
         logic [W2-1:0] tbl [DEPTH];
         for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            assign tbl[i] = W2'(i * i);
         end
         assign sq = tbl[idx];
      end else begin : g_logic
         logic [2*qsq_pkg::QSQ_MAX_N-1:0] sq_wide;
         logic                            unused_hi;
         assign sq_wide   = qsq_pkg::sq_shift_add(
                               {{(qsq_pkg::QSQ_MAX_N-N){1'b0}}, idx});
         assign sq        = sq_wide[W2-1:0];
         assign unused_hi = ^sq_wide;
      end
   endgenerate
endmodule

// File: rtl/qsq_combine.sv
module qsq_combine #(
   parameter int unsigned N = 16
) (
   input  logic [2*N-1:0] sq_x,
   input  logic [2*N-1:0] sq_y,
   input  logic [2*N-1:0] corr,
   output logic [2*N-1:0] prod
);
   // Modulo 2^(2N): a negative x^2-y^2 is cancelled by the correction.
   logic [2*N-1:0] sq_diff;
   assign sq_diff = sq_x - sq_y;
   assign prod    = sq_diff + corr;
endmodule

// File: rtl/qsq_mult.sv
module qsq_mult #(
   parameter int unsigned       N       = 16,
   parameter qsq_pkg::sq_impl_e SQ_IMPL = (N <= 10) ? qsq_pkg::SQ_IMPL_TABLE
                                                    : qsq_pkg::SQ_IMPL_LOGIC
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           in_valid,
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic           out_valid,
   output logic [2*N-1:0] product
);
   localparam int unsigned W2 = 2 * N;

   generate
      if (N < 2 || N > qsq_pkg::QSQ_MAX_N) begin : g_bad_n
         $error("qsq_mult: N must lie in 2..32");
      end
   endgenerate

   logic [N-1:0]  x_idx;
   logic [N-1:0]  y_idx;
   logic [W2-1:0] corr_c;
   logic [W2-1:0] sq_x_c;
   logic [W2-1:0] sq_y_c;

   qsq_operand_prep #(.N(N)) u_prep (
      .a     (a),
      .b     (b),
      .x_idx (x_idx),
      .y_idx (y_idx),
      .corr  (corr_c)
   );

   qsq_square_unit #(.N(N), .SQ_IMPL(SQ_IMPL)) u_sq_x (
      .idx (x_idx),
      .sq  (sq_x_c)
   );

   qsq_square_unit #(.N(N), .SQ_IMPL(SQ_IMPL)) u_sq_y (
      .idx (y_idx),
      .sq  (sq_y_c)
   );

   // Stage 1: lookup results
   logic          s1_valid;
   logic [W2-1:0] s1_sq_x;
   logic [W2-1:0] s1_sq_y;
   logic [W2-1:0] s1_corr;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         s1_valid <= 1'b0;
         s1_sq_x  <= '0;
         s1_sq_y  <= '0;
         s1_corr  <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_sq_x <= sq_x_c;
            s1_sq_y <= sq_y_c;
            s1_corr <= corr_c;
         end
      end
   end

   // Stage 2: combine
   logic [W2-1:0] prod_c;

   qsq_combine #(.N(N)) u_comb (
      .sq_x (s1_sq_x),
      .sq_y (s1_sq_y),
      .corr (s1_corr),
      .prod (prod_c)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         out_valid <= 1'b0;
         product   <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) product <= prod_c;
      end
   end
endmodule

// File: rtl/qsq_mult_checker.sv
module qsq_mult_checker #(
   parameter int unsigned N = 16
) (
   input logic           clk_i,
   input logic           rst_i,
   input logic           in_valid,
   input logic [N-1:0]   a,
   input logic [N-1:0]   b,
   input logic           out_valid,
   input logic [2*N-1:0] product
);
   // R5: accepted pair yields a result two cycles on
   a_r5_valid_latency: assert property (@(posedge clk_i) disable iff (rst_i)
      in_valid |-> ##2 out_valid);

   // R7: no result without an accepted pair two cycles earlier
   a_r7_no_spurious: assert property (@(posedge clk_i) disable iff (rst_i)
      out_valid |-> $past(in_valid, 2));

   // R7: product holds between results
   a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (rst_i)
      !out_valid |-> $stable(product));

   // R2 / R3 / R5: the result equals the true product of the pair
   a_r5_exact_product: assert property (@(posedge clk_i) disable iff (rst_i)
      out_valid |-> product == ({{N{1'b0}}, $past(a, 2)} * {{N{1'b0}}, $past(b, 2)}));

   // R3: odd-parity result bit 0 is zero only if one operand is even
   a_r3_low_bit: assert property (@(posedge clk_i) disable iff (rst_i)
      out_valid |-> product[0] == ($past(a[0], 2) & $past(b[0], 2)));
endmodule

bind qsq_mult qsq_mult_checker #(.N(N)) u_qsq_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .in_valid  (in_valid),
   .a         (a),
   .b         (b),
   .out_valid (out_valid),
   .product   (product)
);

// File: tb/qsq_mult_bench.sv
`timescale 1ns/1ps
module qsq_mult_bench;
   localparam int unsigned N  = 16;
   localparam int unsigned NS = 6;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          vin = 1'b0;
   logic [N-1:0]  a_in = '0;
   logic [N-1:0]  b_in = '0;
   logic          vout;
   logic [2*N-1:0] prod;
   logic          vout_s;
   logic [2*NS-1:0] prod_s;

   int n_vec  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   qsq_mult #(.N(N)) u_qsq_mult (
      .clk_i(clk), .rst_i(rst), .in_valid(vin), .a(a_in), .b(b_in),
      .out_valid(vout), .product(prod));

   qsq_mult #(.N(NS), .SQ_IMPL(qsq_pkg::SQ_IMPL_TABLE)) u_qsq_mult_tbl (
      .clk_i(clk), .rst_i(rst), .in_valid(vin), .a(a_in[NS-1:0]), .b(b_in[NS-1:0]),
      .out_valid(vout_s), .product(prod_s));

   function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
      return {{N{1'b0}}, x} * {{N{1'b0}}, y};
   endfunction

   function automatic logic [2*NS-1:0] ref_mul_s(input logic [N-1:0] x, input logic [N-1:0] y);
      return {{NS{1'b0}}, x[NS-1:0]} * {{NS{1'b0}}, y[NS-1:0]};
   endfunction

   function automatic string tag_of(input logic [N-1:0] x, input logic [N-1:0] y);
      if (x == '1 && y == '1) return "R1";
      if (x[0] != y[0] && x < y) return "R4";
      if (x[0] != y[0]) return "R3";
      return "R2";
   endfunction

   // Pipeline of applied stimulus, used to know what to expect.
   logic          p0_v = 0, p1_v = 0;
   logic [N-1:0]  p0_a = '0, p0_b = '0, p1_a = '0, p1_b = '0;
   logic [2*N-1:0]  last_exp   = '0;
   logic [2*NS-1:0] last_exp_s = '0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [N-1:0] x, input logic [N-1:0] y);
      @(negedge clk);
      check(vout == p1_v, "R5", 64'(vout), 64'(p1_v));
      check(vout_s == p1_v, "R9", 64'(vout_s), 64'(p1_v));
      if (p1_v) begin
         last_exp   = ref_mul(p1_a, p1_b);
         last_exp_s = ref_mul_s(p1_a, p1_b);
         check(prod == last_exp, tag_of(p1_a, p1_b), 64'(prod), 64'(last_exp));
         check(prod_s == last_exp_s, "R9", 64'(prod_s), 64'(last_exp_s));
      end else begin
         check(prod == last_exp, "R7", 64'(prod), 64'(last_exp));
      end
      p1_v = p0_v; p1_a = p0_a; p1_b = p0_b;
      p0_v = v;    p0_a = x;    p0_b = y;
      vin = v; a_in = x; b_in = y;
   endtask

   initial begin : watchdog
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd7));
      repeat (3) @(negedge clk);
      // R6: reset state
      check(vout == 1'b0 && prod == '0, "R6", 64'(prod), 64'd0);
      rst = 1'b0;
      // Directed corner cases (R1..R4, R8 back-to-back)
      step(1, 16'd0, 16'd0);
      step(1, 16'd1, 16'd2);          // R4: y floors to -1
      step(1, 16'd2, 16'd1);
      step(1, '1, '1);                // R1
      step(1, '1, 16'd0);
      step(1, 16'd1, '1);
      step(1, 16'd1234, 16'd1234);    // R2: A = B
      step(1, 16'd7, 16'd10);         // R3 / R4
      step(1, 16'd10, 16'd7);         // R3
      step(1, 16'h8000, 16'h7fff);
      step(1, 16'h7fff, 16'h8000);
      step(1, '1, 16'd1);
      // Gapped stream: R7 hold
      step(0, 16'hdead, 16'hbeef);
      step(0, 16'd0, 16'd0);
      step(0, 16'd0, 16'd0);
      step(1, 16'd3, 16'd5);
      step(0, 16'd0, 16'd0);
      step(0, 16'd0, 16'd0);
      // Constrained random, mixed density (R2, R3, R8, R9)
      for (int i = 0; i < 3000; i++) begin
         logic [N-1:0] ra, rb;
         logic rv;
         ra = N'($urandom);
         rb = N'($urandom);
         if (i % 5 == 0) rb = ra;
         if (i % 7 == 0) rb = {rb[N-1:1], ~ra[0]};
         rv = (i < 1500) ? 1'b1 : ($urandom_range(0, 3) != 0);
         step(rv, ra, rb);
      end
      step(0, '0, '0);
      step(0, '0, '0);
      step(0, '0, '0);
      // R6: reset clears the held product
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(vout == 1'b0 && prod == '0, "R6", 64'(prod), 64'd0);
      check(vout_s == 1'b0 && prod_s == '0, "R6", 64'(prod_s), 64'd0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule